// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix-Multiply Array

A rectangular grid of multiply-accumulate cells that forms output vectors of C = A x B by streaming. Work runs in two phases. In the load phase, rows of the weight matrix B are pushed in at the top edge and shift down one grid row per accepted beat until every cell holds its own weight. In the compute phase, each input vector (one row of A) enters at the left edge. Grid row r takes element r of the vector, skewed so that row r arrives r cycles after row 0. Operands move right one cell per cycle. Partial sums move down one cell per cycle, and each cell adds its weight times its operand to the partial sum. The finished sum of each column leaves at the bottom edge.

A starting value can be injected at the top of every column, so an output tile held in an outside buffer can keep accumulating over several passes through the array. The grid height (the reduction length) and width (the number of output columns) are parameters. Operands are signed 8-bit values, and sums are 32-bit two's complement values that wrap on overflow.

Top module: `sa_gemm_top`

## Requirements
- R1: While reset is low and after it is released, with no traffic, `res_valid_o` is all zero and `wload_done_o` is zero.
- R2: Each clock edge with `wload_valid_i` high captures `wload_row_i` into grid row 0 and moves every stored weight down one row. After ROWS beats, the k-th beat (counting from 0) sits in grid row ROWS-1-k. Column c takes bits [8c+7:8c]. Weights do not change on edges where `wload_valid_i` is low, whatever `wload_row_i` holds.
- R3: `wload_done_o` is high for exactly one cycle, right after the edge that captures the ROWS-th valid beat of a load. Edges with `wload_valid_i` low do not count as beats.
- R4: For an input vector a, column c produces start + sum over r of W[r][c]*a[r], where W[r][c] is the weight in grid row r, column c.
- R5: Let edge e capture row 0 of a vector. Then row r must be presented with `a_valid_i[r]` high at edge e+r, with its operand on `a_row_i` bits [8r+7:8r]. The result of column c shows on `res_row_o` bits [32c+31:32c], with `res_valid_o[c]` high for one cycle, right after edge e+ROWS+c-1.
- R6: The start value for column c is `ps_row_i` bits [32c+31:32c], taken at edge e+c when `ps_valid_i[c]` is high. When `ps_valid_i[c]` is low at that edge, the start value is zero.
- R7: Operands are signed two's complement 8-bit values, products are sign-extended, and the 32-bit sum wraps modulo 2^32.
- R8: Vectors may be issued on consecutive edges or with gaps, using the same stored weights. Each vector gives its own independent result.
- R9: `res_valid_o[c]` is low on every cycle where no result is due under R5. Operand data presented with `a_valid_i` low affects no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wload_valid_i | input | 1 | Weight beat valid; shifts weights down |
| wload_row_i | input | COLS*8 | One weight row, column c at [8c+7:8c] |
| wload_done_o | output | 1 | Pulse after ROWS weight beats |
| a_valid_i | input | ROWS | Per-row operand valid (skewed) |
| a_row_i | input | ROWS*8 | Left-edge operands, row r at [8r+7:8r] |
| ps_valid_i | input | COLS | Per-column start-value valid (skewed) |
| ps_row_i | input | COLS*32 | Top-edge start values, column c at [32c+31:32c] |
| res_valid_o | output | COLS | Per-column result valid |
| res_row_o | output | COLS*32 | Bottom-edge results, column c at [32c+31:32c] |

## Verification
The bench uses a non-square grid. If rows and columns were swapped, or if the weight order were inverted during the load, results would land in the wrong columns and the per-column latency would be off by the grid's height-width difference. It sends vectors back-to-back and with gaps, and it holds garbage on data lanes whose valid is low. An array that let a stale operand or a stale sum leak into the next vector would produce wrong sums or spurious valid pulses. It loads extreme weights and operands together with a large start value so that the sum crosses 2^31. An unsigned multiplier or a missing sign extension would give a result far from the wrapped value. It inserts a gap in the middle of a weight load, which a done counter that counts cycles rather than beats would signal too early.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int DATA_W = 8;
  localparam int ACC_W  = 32;
  typedef logic signed [DATA_W-1:0] operand_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
endpackage

// File: rtl/sa_load_ctrl.sv
module sa_load_ctrl #(
  parameter int ROWS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic beat_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(ROWS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROWS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (beat_i) begin
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      done_o <= (cnt_q == LAST);
    end else begin
      done_o <= 1'b0;
    end
  end

  // R3
  done_after_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(beat_i));

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  if (ROWS > 1) begin : g_pulse
    // R3
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
  end
endmodule

// File: rtl/sa_pe.sv
module sa_pe
  import sa_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     w_load_i,
  input  operand_t w_i,
  output operand_t w_o,
  input  logic     a_valid_i,
  input  operand_t a_i,
  output logic     a_valid_o,
  output operand_t a_o,
  input  acc_t     ps_i,
  output acc_t     ps_o
);
  logic signed [2*DATA_W-1:0] prod;
  assign prod = w_o * a_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_o       <= '0;
      a_valid_o <= 1'b0;
      a_o       <= '0;
      ps_o      <= '0;
    end else begin
      if (w_load_i) w_o <= w_i;
      a_valid_o <= a_valid_i;
      if (a_valid_i) begin
        a_o  <= a_i;
        ps_o <= ps_i + acc_t'(prod);  // wraps modulo 2^ACC_W
      end
    end
  end

  // R2
  w_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !w_load_i |=> $stable(w_o));

  // R9
  ps_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_valid_i |=> $stable(ps_o) && $stable(a_o));

  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_valid_i |=> !a_valid_o);
endmodule

// File: rtl/sa_gemm_top.sv
module sa_gemm_top
  import sa_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wload_valid_i,
  input  logic [COLS*DATA_W-1:0]  wload_row_i,
  output logic                    wload_done_o,
  input  logic [ROWS-1:0]         a_valid_i,
  input  logic [ROWS*DATA_W-1:0]  a_row_i,
  input  logic [COLS-1:0]         ps_valid_i,
  input  logic [COLS*ACC_W-1:0]   ps_row_i,
  output logic [COLS-1:0]         res_valid_o,
  output logic [COLS*ACC_W-1:0]   res_row_o
);
  operand_t w_ch  [ROWS+1][COLS];
  acc_t     p_ch  [ROWS+1][COLS];
  operand_t a_ch  [ROWS][COLS+1];
  logic     a_vch [ROWS][COLS+1];

  logic [ROWS-1:0] unused_east;
  logic [COLS-1:0] unused_south;

  sa_load_ctrl #(.ROWS(ROWS)) u_load_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (wload_valid_i),
    .done_o (wload_done_o)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_top
    assign w_ch[0][c] = operand_t'(wload_row_i[c*DATA_W +: DATA_W]);
    assign p_ch[0][c] = ps_valid_i[c] ? acc_t'(ps_row_i[c*ACC_W +: ACC_W]) : '0;
    assign res_row_o[c*ACC_W +: ACC_W] = p_ch[ROWS][c];
    assign res_valid_o[c] = a_vch[ROWS-1][c+1];
    assign unused_south[c] = ^w_ch[ROWS][c];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign a_ch[r][0]  = operand_t'(a_row_i[r*DATA_W +: DATA_W]);
    assign a_vch[r][0] = a_valid_i[r];
    assign unused_east[r] = a_vch[r][COLS] ^ (^a_ch[r][COLS]);

    for (genvar c = 0; c < COLS; c++) begin : g_col
      sa_pe u_pe (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .w_load_i  (wload_valid_i),
        .w_i       (w_ch[r][c]),
        .w_o       (w_ch[r+1][c]),
        .a_valid_i (a_vch[r][c]),
        .a_i       (a_ch[r][c]),
        .a_valid_o (a_vch[r][c+1]),
        .a_o       (a_ch[r][c+1]),
        .ps_i      (p_ch[r][c]),
        .ps_o      (p_ch[r+1][c])
      );
    end
  end

  // R1
  idle_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> (res_valid_o == '0) && !wload_done_o);
endmodule

// File: tb/sim_sa_gemm_top.sv
module sim_sa_gemm_top;
  import sa_pkg::*;

  localparam int ROWS = 6;
  localparam int COLS = 5;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = 8;

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   wload_valid;
  logic [COLS*DATA_W-1:0] wload_row;
  logic                   wload_done;
  logic [ROWS-1:0]        a_valid;
  logic [ROWS*DATA_W-1:0] a_row;
  logic [COLS-1:0]        ps_valid;
  logic [COLS*ACC_W-1:0]  ps_row;
  logic [COLS-1:0]        res_valid;
  logic [COLS*ACC_W-1:0]  res_row;

  int tests = 0;
  int fails = 0;
  int n_edges = 0;

  int          w_ref [ROWS][COLS];
  int          a_m   [MAXV][ROWS];
  logic [31:0] ps_m  [MAXV][COLS];
  bit          ps_en [MAXV];
  int          start_e [MAXV];
  int          off   [MAXV];
  int          nv;
  bit          wrap_set;

  sa_gemm_top #(.ROWS(ROWS), .COLS(COLS)) u0 (
    .clk_i (clk), .rst_ni (rst_ni),
    .wload_valid_i (wload_valid), .wload_row_i (wload_row), .wload_done_o (wload_done),
    .a_valid_i (a_valid), .a_row_i (a_row),
    .ps_valid_i (ps_valid), .ps_row_i (ps_row),
    .res_valid_o (res_valid), .res_row_o (res_row)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) n_edges <= n_edges + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, n_edges);
    end
  endtask

  task automatic load_weights(input bit extreme);
    for (int k = 0; k < ROWS; k++) begin
      int gr = ROWS - 1 - k;
      wload_valid = 1'b1;
      for (int c = 0; c < COLS; c++) begin
        int v = extreme ? (((gr + c) % 3 == 0) ? 127 : -128) : int'($signed(8'($urandom)));
        w_ref[gr][c] = v;
        wload_row[c*DATA_W +: DATA_W] = 8'(v);
      end
      @(negedge clk);
      chk(wload_done == (k == ROWS-1), "R3", 32'(wload_done), 32'(k == ROWS-1));
      if (k == 1) begin
        // gap: R2 hold, R3 beat counting
        wload_valid = 1'b0;
        wload_row = COLS*DATA_W'($urandom);
        @(negedge clk);
        chk(wload_done == 1'b0, "R3", 32'(wload_done), 32'd0);
      end
    end
    wload_valid = 1'b0;
    wload_row = COLS*DATA_W'($urandom);
    @(negedge clk);
    chk(wload_done == 1'b0, "R3", 32'(wload_done), 32'd0);
  endtask

  function automatic logic [31:0] expect_sum(input int v, input int c);
    logic [31:0] acc = ps_en[v] ? ps_m[v][c] : 32'd0;
    for (int r = 0; r < ROWS; r++) acc = acc + 32'(w_ref[r][c] * a_m[v][r]);
    return acc;
  endfunction

  // called at a negedge; vectors start at base+1+off[v]
  task automatic run_stream();
    int base = n_edges;
    int last = 0;
    for (int v = 0; v < nv; v++) begin
      start_e[v] = base + 1 + off[v];
      if (start_e[v] + ROWS + COLS > last) last = start_e[v] + ROWS + COLS;
    end
    while (n_edges <= last) begin
      int n = n_edges;
      int e = n + 1;
      for (int c = 0; c < COLS; c++) begin
        bit expv = 1'b0;
        logic [31:0] expd = '0;
        for (int v = 0; v < nv; v++)
          if (start_e[v] + ROWS + c - 1 == n) begin
            expv = 1'b1;
            expd = expect_sum(v, c);
          end
        chk(res_valid[c] == expv, expv ? "R5" : "R9", 32'(res_valid[c]), 32'(expv));
        if (expv)
          chk(res_row[c*ACC_W +: ACC_W] == expd, wrap_set ? "R7" : "R4",
              res_row[c*ACC_W +: ACC_W], expd);
      end
      a_valid  = '0;
      a_row    = ROWS*DATA_W'({$urandom, $urandom});
      ps_valid = '0;
      for (int c = 0; c < COLS; c++) ps_row[c*ACC_W +: ACC_W] = $urandom;
      wload_row = COLS*DATA_W'($urandom);
      for (int v = 0; v < nv; v++) begin
        for (int r = 0; r < ROWS; r++)
          if (start_e[v] + r == e) begin
            a_valid[r] = 1'b1;
            a_row[r*DATA_W +: DATA_W] = 8'(a_m[v][r]);
          end
        for (int c = 0; c < COLS; c++)
          if (start_e[v] + c == e && ps_en[v]) begin
            ps_valid[c] = 1'b1;
            ps_row[c*ACC_W +: ACC_W] = ps_m[v][c];
          end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    wload_valid = 1'b0;
    wload_row   = '0;
    a_valid     = '0;
    a_row       = '0;
    ps_valid    = '0;
    ps_row      = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(res_valid == '0, "R1", 32'(res_valid), 32'd0);
    chk(wload_done == 1'b0, "R1", 32'(wload_done), 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // R1 after release
    chk(res_valid == '0, "R1", 32'(res_valid), 32'd0);
    chk(wload_done == 1'b0, "R1", 32'(wload_done), 32'd0);

    // R2 R3: random weights with a gap mid-load
    load_weights(1'b0);

    // R4 R5 R6 R8 R9: back-to-back, gapped, with and without start values
    wrap_set = 1'b0;
    nv = 6;
    for (int v = 0; v < nv; v++) begin
      off[v] = (v < 4) ? v : 6 + 3 * v;
      ps_en[v] = (v % 2 == 1);
      for (int r = 0; r < ROWS; r++) a_m[v][r] = int'($signed(8'($urandom)));
      for (int c = 0; c < COLS; c++) ps_m[v][c] = $urandom;
    end
    run_stream();

    // R8: same weights reused after idle time
    nv = 2;
    off[0] = 2; off[1] = 3;
    ps_en[0] = 1'b1; ps_en[1] = 1'b0;
    for (int v = 0; v < 2; v++)
      for (int r = 0; r < ROWS; r++) a_m[v][r] = (r % 2 == 0) ? 127 : -128;
    for (int c = 0; c < COLS; c++) ps_m[0][c] = 32'hffff_fff0;
    run_stream();

    // R2: reload with extreme weights; R7 wrap across 2^31
    load_weights(1'b1);
    wrap_set = 1'b1;
    nv = 3;
    for (int v = 0; v < nv; v++) begin
      off[v] = v;
      ps_en[v] = 1'b1;
      for (int r = 0; r < ROWS; r++) a_m[v][r] = (v == 2) ? 127 : -128;
      for (int c = 0; c < COLS; c++) ps_m[v][c] = (v == 1) ? 32'h8000_0010 : 32'h7fff_f000;
    end
    run_stream();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule